// File: doc/BRIEF.md
# Switchable Three-Pole Stereo Audio Lowpass

This block smooths a stereo audio stream whose amplitude is carried as a fast pulse train. It applies three first-order recursive lowpass sections in cascade. The first section models a fixed tone-shaping network whose corner can be moved. The second and third sections together form an optional steeper stage. No section is ever taken out of the signal path. To "switch off" a section, the block swaps in a coefficient that puts its corner near 1 MHz, far above anything audible, and the section keeps filtering.

One arithmetic datapath serves both channels. Each processing enable pulse updates the three sections of one channel, and the next pulse updates the other channel. The enable therefore runs at twice the per-channel rate. The coefficients assume a per-channel rate of about 3.5 MHz, fast enough to see every input pulse. A separate, much slower sample enable (48 kHz or 96 kHz) copies the final section's result to the outputs. When the master filter switch is off, that copy takes the raw input instead. The sections run on in the background either way.

Top module: `lpf3_stereo`

## Requirements
- R1: Each section computes y' = y + floor((x − y)·k / 2^16), where k is an unsigned 16-bit coefficient. The state y is a signed value with 16 fractional bits, one guard bit and 16 integer bits. The first section's x is the input sample times 2^16. The output is floor(y3 / 2^16), clamped to the signed 16-bit range.
- R2: Section 1 uses k = 519 when model_sel is 0 (corner near 4.43 kHz at a 3.5 MHz per-channel rate). It uses k = 54650 when model_sel is 1 (corner near 1 MHz).
- R3: When stage2_en is 1, sections 2 and 3 use k = 352 and k = 399 (corners near 3.0 kHz and 3.4 kHz). When stage2_en is 0, both use k = 54650.
- R4: Section 2 takes the full-precision new value of section 1 from the same pulse, and section 3 does the same with section 2, with no rounding to 16 bits between sections. A small DC input still works its way through to the output.
- R5: Each proc_ce pulse updates only one channel. The first pulse after reset updates the left channel, and the channel then alternates on every pulse. A channel's state does not change on the other channel's pulses.
- R6: When filt_en is 0, a smp_ce pulse copies in_l and in_r to the outputs. The filter state keeps updating, so turning filt_en back on shows the state that accumulated in the meantime.
- R7: The outputs change only in the cycle after a smp_ce pulse. They then hold the clamped final-section value that each channel had before that edge, and stay fixed until the next smp_ce.
- R8: A synchronous reset clears all six section states and both outputs to zero, and selects the left channel.
- R9: A coefficient change takes effect on the next proc_ce pulse and never clears any state.
- R10: With all sections at the 1 MHz setting, a constant input drives each output to within 1 LSB of that input after 40 updates per channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_ce | input | 1 | Processing enable; each pulse updates one channel |
| smp_ce | input | 1 | Output sample enable |
| model_sel | input | 1 | Section 1 corner select: 0 low corner, 1 open |
| stage2_en | input | 1 | 1 selects the low corners for sections 2 and 3 |
| filt_en | input | 1 | Master switch: 0 sends the raw input to the outputs |
| in_l | input | 16 | Left input sample, signed |
| in_r | input | 16 | Right input sample, signed |
| out_l | output | 16 | Left output sample, signed |
| out_r | output | 16 | Right output sample, signed |

## Verification
The bench holds a bit-exact model of the cascade and compares against it across changes of corner, level and master switch, carrying state from one run into the next. That catches a design that resets state on a coefficient swap or truncates between sections: with a 100 LSB input under the low corners, such a design lands on a different integer than the model. Separate checks confirm that the first pulse after reset goes to the left channel, that the outputs hold between sample pulses, and that bypass copies the raw input while the filter keeps running. A swapped channel order, an output that follows the state on every pulse, or a bypass that freezes the sections would each give a value the model does not predict.

// File: rtl/lpf3_pkg.sv
package lpf3_pkg;
    localparam int NPOLE     = 3;
    // coefficients for a per-channel update rate of about 3.5 MHz, scale 2^16
    localparam int K_TONE    = 519;    // ~4.43 kHz
    localparam int K_STEEP_A = 352;    // ~3.0 kHz
    localparam int K_STEEP_B = 399;    // ~3.4 kHz
    localparam int K_OPEN    = 54650;  // ~1 MHz, effectively transparent
endpackage

// File: rtl/lpf_pole.sv
module lpf_pole #(
    parameter int SW = 33,
    parameter int KW = 16
) (
    input  logic signed [SW-1:0] x_i,
    input  logic signed [SW-1:0] y_i,
    input  logic        [KW-1:0] k_i,
    output logic signed [SW-1:0] y_o
);
    localparam int DWD = SW + 1;
    localparam int PW  = DWD + KW + 1;

    logic signed [DWD-1:0] diff;
    logic signed [PW-1:0]  prod;

    always_comb begin
        diff = DWD'(x_i) - DWD'(y_i);
        prod = PW'(diff) * PW'($signed({1'b0, k_i}));
        y_o  = SW'(PW'(y_i) + (prod >>> KW));
    end
endmodule

// File: rtl/lpf_sat.sv
module lpf_sat #(
    parameter int DW   = 16,
    parameter int FRAC = 16,
    parameter int SW   = 33
) (
    input  logic signed [SW-1:0] y_i,
    output logic signed [DW-1:0] s_o
);
    localparam int IW = SW - FRAC;
    localparam logic signed [IW-1:0] HI = IW'((2 ** (DW - 1)) - 1);
    localparam logic signed [IW-1:0] LO = -HI - IW'(1);

    logic signed [IW-1:0] ip;

    always_comb begin
        ip = IW'(y_i >>> FRAC);
        if (ip > HI)      s_o = DW'(HI);
        else if (ip < LO) s_o = DW'(LO);
        else              s_o = DW'(ip);
    end
endmodule

// File: rtl/lpf_coef_sel.sv
module lpf_coef_sel
    import lpf3_pkg::*;
#(
    parameter int KW = 16
) (
    input  logic                       model_i,
    input  logic                       steep_i,
    output logic [NPOLE-1:0][KW-1:0]   k_o
);
    always_comb begin
        k_o[0] = model_i ? KW'(K_OPEN) : KW'(K_TONE);
        k_o[1] = steep_i ? KW'(K_STEEP_A) : KW'(K_OPEN);
        k_o[2] = steep_i ? KW'(K_STEEP_B) : KW'(K_OPEN);
    end
endmodule

// File: rtl/lpf3_stereo.sv
module lpf3_stereo
    import lpf3_pkg::*;
#(
    parameter int DW    = 16,
    parameter int FRAC  = 16,
    parameter int GUARD = 1,
    parameter int KW    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 proc_ce,
    input  logic                 smp_ce,
    input  logic                 model_sel,
    input  logic                 stage2_en,
    input  logic                 filt_en,
    input  logic signed [DW-1:0] in_l,
    input  logic signed [DW-1:0] in_r,
    output logic signed [DW-1:0] out_l,
    output logic signed [DW-1:0] out_r
);
    localparam int SW = DW + GUARD + FRAC;

    typedef struct packed {
        logic [1:0][NPOLE-1:0][SW-1:0] y;
        logic                          ch;
        logic [DW-1:0]                 o_l;
        logic [DW-1:0]                 o_r;
    } state_t;

    state_t st_q, st_d;

    logic [NPOLE-1:0][KW-1:0] kv;
    logic [NPOLE-1:0][SW-1:0] ycur, ynext;
    logic signed [DW-1:0]     x_sel;
    logic signed [SW-1:0]     x_ext;
    logic signed [DW-1:0]     sat_l, sat_r;

    assign x_sel = st_q.ch ? in_r : in_l;
    assign x_ext = {{GUARD{x_sel[DW-1]}}, x_sel, {FRAC{1'b0}}};
    assign ycur  = st_q.y[st_q.ch];

    lpf_coef_sel #(.KW(KW)) u_coef (
        .model_i (model_sel),
        .steep_i (stage2_en),
        .k_o     (kv)
    );

    for (genvar i = 0; i < NPOLE; i++) begin : g_pole
        logic signed [SW-1:0] yn;
        if (i == 0) begin : g_first
            lpf_pole #(.SW(SW), .KW(KW)) u_pole (
                .x_i (x_ext),
                .y_i ($signed(ycur[i])),
                .k_i (kv[i]),
                .y_o (yn)
            );
        end else begin : g_next
            lpf_pole #(.SW(SW), .KW(KW)) u_pole (
                .x_i ($signed(ynext[i-1])),
                .y_i ($signed(ycur[i])),
                .k_i (kv[i]),
                .y_o (yn)
            );
        end
        assign ynext[i] = yn;
    end

    lpf_sat #(.DW(DW), .FRAC(FRAC), .SW(SW)) u_sat_l (
        .y_i ($signed(st_q.y[0][NPOLE-1])),
        .s_o (sat_l)
    );

    lpf_sat #(.DW(DW), .FRAC(FRAC), .SW(SW)) u_sat_r (
        .y_i ($signed(st_q.y[1][NPOLE-1])),
        .s_o (sat_r)
    );

    always_comb begin
        st_d = st_q;
        if (proc_ce) begin
            st_d.y[st_q.ch] = ynext;
            st_d.ch         = ~st_q.ch;
        end
        if (smp_ce) begin
            st_d.o_l = filt_en ? sat_l : in_l;
            st_d.o_r = filt_en ? sat_r : in_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_l = $signed(st_q.o_l);
    assign out_r = $signed(st_q.o_r);
endmodule

// File: rtl/lpf3_stereo_chk.sv
module lpf3_stereo_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 proc_ce,
    input logic                 smp_ce,
    input logic                 filt_en,
    input logic signed [DW-1:0] in_l,
    input logic signed [DW-1:0] in_r,
    input logic signed [DW-1:0] out_l,
    input logic signed [DW-1:0] out_r,
    input logic                 ch
);
    // R8: reset clears outputs and points at the left channel
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (out_l == '0 && out_r == '0 && ch == 1'b0));

    // R5: channel flips on every processing pulse
    p_chan_flip_r5: assert property (@(posedge clk) disable iff (rst)
        proc_ce |=> ch != $past(ch));

    // R5: channel holds without a processing pulse
    p_chan_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !proc_ce |=> $stable(ch));

    // R7: outputs move only after a sample pulse
    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_ce |=> ($stable(out_l) && $stable(out_r)));

    // R6: bypass copies the raw inputs
    p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
        (smp_ce && !filt_en) |=> (out_l == $past(in_l) && out_r == $past(in_r)));
endmodule

bind lpf3_stereo lpf3_stereo_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .proc_ce (proc_ce),
    .smp_ce  (smp_ce),
    .filt_en (filt_en),
    .in_l    (in_l),
    .in_r    (in_r),
    .out_l   (out_l),
    .out_r   (out_r),
    .ch      (st_q.ch)
);

// File: tb/sim_lpf3_stereo.sv
module sim_lpf3_stereo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic proc_ce = 1'b0, smp_ce = 1'b0;
    logic model_sel = 1'b0, stage2_en = 1'b0, filt_en = 1'b1;
    logic signed [15:0] in_l = '0, in_r = '0;
    logic signed [15:0] out_l, out_r;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lpf3_stereo u0 (
        .clk(clk), .rst(rst), .proc_ce(proc_ce), .smp_ce(smp_ce),
        .model_sel(model_sel), .stage2_en(stage2_en), .filt_en(filt_en),
        .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
    );

    typedef struct packed {
        logic signed [15:0] l;
        logic signed [15:0] r;
        logic               model;
        logic               st2;
        logic               fen;
        logic [11:0]        n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'sd10000,  -16'sd10000, 1'b0, 1'b1, 1'b1, 12'd400},
        '{16'sd32767,  -16'sd32768, 1'b1, 1'b0, 1'b1, 12'd60},
        '{16'sd0,       16'sd0,     1'b0, 1'b0, 1'b1, 12'd200},
        '{-16'sd5000,   16'sd12000, 1'b1, 1'b1, 1'b1, 12'd300},
        '{16'sd20000,   16'sd20000, 1'b0, 1'b1, 1'b0, 12'd100},
        '{16'sd100,    -16'sd100,   1'b0, 1'b1, 1'b1, 12'd3000},
        '{-16'sd32768,  16'sd32767, 1'b1, 1'b1, 1'b1, 12'd500},
        '{16'sd1234,   -16'sd4321,  1'b0, 1'b0, 1'b1, 12'd150}
    };

    // bit-exact reference from the requirements
    longint my [2][3];
    int     mch;

    function automatic longint pstep(longint x, longint y, longint k);
        longint p;
        p = (x - y) * k;
        return y + (p >>> 16);
    endfunction

    function automatic int msat(longint y);
        longint v;
        v = y >>> 16;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return int'(v);
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < 3; p++) my[c][p] = 0;
        mch = 0;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic pulse_ce();
        longint k0, k1, k2, x;
        k0 = model_sel ? 54650 : 519;
        k1 = stage2_en ? 352 : 54650;
        k2 = stage2_en ? 399 : 54650;
        x  = (mch == 1 ? longint'(in_r) : longint'(in_l)) * 65536;
        my[mch][0] = pstep(x, my[mch][0], k0);
        my[mch][1] = pstep(my[mch][0], my[mch][1], k1);
        my[mch][2] = pstep(my[mch][1], my[mch][2], k2);
        mch = 1 - mch;
        proc_ce = 1'b1;
        @(negedge clk);
        proc_ce = 1'b0;
    endtask

    task automatic sample(output int el, output int er);
        el = filt_en ? msat(my[0][2]) : int'(in_l);
        er = filt_en ? msat(my[1][2]) : int'(in_r);
        smp_ce = 1'b1;
        @(negedge clk);
        smp_ce = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int el, er, hl, hr;
        @(negedge clk);
        do_reset();
        check("R8 reset out_l", int'(out_l), 0);
        check("R8 reset out_r", int'(out_r), 0);

        // vector walk; state carries across rows (R9, R6 continuity)
        for (int v = 0; v < NV; v++) begin
            in_l = VEC[v].l; in_r = VEC[v].r;
            model_sel = VEC[v].model; stage2_en = VEC[v].st2; filt_en = VEC[v].fen;
            for (int n = 0; n < int'(VEC[v].n); n++) pulse_ce();
            sample(el, er);
            check("R1 R2 R3 R9 vector left", int'(out_l), el);
            check("R1 R2 R3 R9 vector right", int'(out_r), er);
            if (!VEC[v].fen) begin
                check("R6 bypass left", int'(out_l), int'(VEC[v].l));
                check("R6 bypass right", int'(out_r), int'(VEC[v].r));
            end
            if (v == 5) check("R4 small dc reaches output", int'(out_l > 0), 1);
        end

        // R6: state kept running during bypass, resume shows it
        filt_en = 1'b0; in_l = 16'sd8000; in_r = -16'sd8000;
        for (int n = 0; n < 40; n++) pulse_ce();
        filt_en = 1'b1;
        sample(el, er);
        check("R6 resume left", int'(out_l), el);
        check("R6 resume right", int'(out_r), er);

        // R7: outputs hold without sample pulse
        hl = int'(out_l); hr = int'(out_r);
        in_l = -16'sd30000; in_r = 16'sd30000;
        for (int n = 0; n < 20; n++) pulse_ce();
        check("R7 hold left", int'(out_l), hl);
        check("R7 hold right", int'(out_r), hr);

        // R5: first pulse after reset touches left only
        do_reset();
        model_sel = 1'b1; stage2_en = 1'b0; filt_en = 1'b1;
        in_l = 16'sd16000; in_r = -16'sd16000;
        pulse_ce();
        sample(el, er);
        check("R5 first pulse left", int'(out_l), el);
        check("R5 right untouched", int'(out_r), 0);
        pulse_ce();
        sample(el, er);
        check("R5 second pulse right", int'(out_r), er);
        check("R5 left unchanged by right pulse", int'(out_l), el);

        // R10: open sections settle to input
        in_l = 16'sd25000; in_r = -16'sd7;
        for (int n = 0; n < 80; n++) pulse_ce();
        sample(el, er);
        check("R10 open settle left", int'((out_l - in_l) <= 1 && (in_l - out_l) <= 1), 1);
        check("R10 open settle right", int'((out_r - in_r) <= 1 && (in_r - out_r) <= 1), 1);

        // R9: flip coefficients mid-run, state continues
        stage2_en = 1'b1; model_sel = 1'b0;
        for (int n = 0; n < 6; n++) pulse_ce();
        sample(el, er);
        check("R9 switch left", int'(out_l), el);
        check("R9 switch right", int'(out_r), er);

        // R8: mid-run reset
        do_reset();
        check("R8 midrun reset left", int'(out_l), 0);
        check("R8 midrun reset right", int'(out_r), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule